// File: doc/BRIEF.md
# Extended Physical Address Page Walker

This block turns a 32-bit linear address into a 36-bit physical address. It does this by reading paging tables that sit in memory. It fetches one table entry at a time through a request/acknowledge memory port that always returns the aligned 64-bit doubleword. At most one walk is in progress at any time. When the walk ends, the block pulses `done` for one cycle. The physical address, the page size and the fault flag stay valid until the next request is accepted.

The walk depends on two mode-control bits. When the extended bit (bit 5) is set, the walk has up to three levels:
- a four-entry pointer table, located through the table base register;
- a 512-entry directory of 64-bit entries;
- a 512-entry page table.

A directory entry with its page-size bit set ends the walk early with a 2 MB page. In this mode the physical address can reach 64 GB.

When the extended bit is clear, the walker uses the legacy 32-bit two-level format with 4-byte entries. In legacy mode, the large-page bit (bit 4) allows 4 MB pages. The upper four physical address bits are then always zero. The extended bit takes precedence over the large-page bit.

Top module: `page_walker`

## Requirements
- R1: After reset, `done`, `memReq` and `fault` are 0 and `physAddr` is 0.
- R2: With `modeCtl[5]`=0, the walk uses 32-bit entries. Address bit 2 of the entry selects the high (1) or low (0) half of the returned doubleword. The directory entry sits at {tableBase[31:12], lin[31:22], 2'b00}. The page-table entry sits at {pde[31:12], lin[21:12], 2'b00}. The result is {4'h0, pte[31:12], lin[11:0]}, so `physAddr[35:32]` is always 0 in this mode.
- R3: With `modeCtl[5]`=1, the first read is at {tableBase[31:5], lin[31:30], 3'b000}. Base bits 4..0 are ignored, and every extended read address is 8-byte aligned.
- R4: A pointer entry's bits 35..12 form the directory base. Its bits 63..36 are ignored. The directory entry sits at {ptr[35:12], lin[29:21], 3'b000}.
- R5: In extended mode with directory bit 7 clear, the page-table entry sits at {pde[35:12], lin[20:12], 3'b000}. The result is {pte[35:12], lin[11:0]}, with `pageSize`=0 (4 KB) after three reads.
- R6: In extended mode with directory bit 7 set, the result is {pde[35:21], lin[20:0]}, with `pageSize`=1 (2 MB) after two reads.
- R7: With `modeCtl[5]`=0 and `modeCtl[4]`=1, a directory entry with bit 7 set gives {4'h0, pde[31:22], lin[21:0]}, with `pageSize`=2 (4 MB) after one read. With `modeCtl[4]`=0, bit 7 is ignored. With `modeCtl[5]`=1, `modeCtl[4]` has no effect.
- R8: If bit 0 (present) of any fetched entry is 0, the walk ends at once. `fault` is then 1, `physAddr` is 0, and no further read is issued.
- R9: `done` is high for exactly one cycle per walk. `physAddr`, `pageSize` and `fault` hold their values until the next request is accepted.
- R10: `memReq` stays high until `memAck`. A `reqValid` seen while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk (accepted when idle) |
| reqLinAddr | input | 32 | Linear address to translate |
| tableBase | input | 32 | Table base register |
| modeCtl | input | 8 | Mode bits: 5 = extended addressing, 4 = legacy large pages |
| memReq | output | 1 | Entry read request |
| memAddr | output | 36 | Byte address of the entry being read |
| memAck | input | 1 | Read data valid |
| memData | input | 64 | Aligned doubleword containing the entry |
| done | output | 1 | One-cycle end-of-walk strobe |
| physAddr | output | 36 | Translated physical address |
| pageSize | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 4 MB |
| fault | output | 1 | Walk hit a non-present entry |

## Verification
The assertions check, on every cycle, several properties of the handshake and of the outputs:
- the read request stays high until it is acknowledged;
- `done` lasts a single cycle;
- a faulted result never carries an address;
- extended reads are aligned;
- legacy results never set the upper four bits.

Only the bench scenarios can show that each level reads the correct entry and that the three page sizes compose the correct address. The same goes for the following behaviours:
- the mode precedence and the ignored page-size bit;
- the legacy half-word selection;
- the ignoring of requests during a busy walk.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int LIN_W   = 32;
  localparam int PHYS_W  = 36;
  localparam int ENT_W   = 64;
  localparam int MODE_W  = 8;
  localparam int EXT_BIT = 5;
  localparam int LGPG_BIT = 4;
  localparam int FRAME_LO = 12;

  typedef enum logic [1:0] {LV_PTR, LV_DIR, LV_TBL} walkLevel_t;
  typedef enum logic [1:0] {PG_4K = 2'd0, PG_2M = 2'd1, PG_4M = 2'd2} pageSize_t;

  typedef struct packed {
    logic       latchReq;
    logic       capture;
    walkLevel_t level;
  } walkStrobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        extMode,
  input  logic        memAck,
  input  logic        entryPresent,
  input  logic        entryLarge,
  output walkStrobe_t strobe,
  output logic        memReq,
  output logic        done
);
  typedef enum logic [2:0] {S_IDLE, S_PTR, S_DIR, S_TBL, S_FIN} ctlState_t;
  ctlState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: if (reqValid) stateD = extMode ? S_PTR : S_DIR;
      S_PTR:  if (memAck) stateD = entryPresent ? S_DIR : S_FIN;
      S_DIR:  if (memAck) stateD = (!entryPresent || entryLarge) ? S_FIN : S_TBL;
      S_TBL:  if (memAck) stateD = S_FIN;
      S_FIN:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  assign memReq = (stateQ == S_PTR) || (stateQ == S_DIR) || (stateQ == S_TBL);
  assign done   = (stateQ == S_FIN);

  always_comb begin
    strobe.latchReq = (stateQ == S_IDLE) && reqValid;
    strobe.capture  = memReq && memAck;
    unique case (stateQ)
      S_PTR:   strobe.level = LV_PTR;
      S_TBL:   strobe.level = LV_TBL;
      default: strobe.level = LV_DIR;
    endcase
  end

  // R10: request held until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> memReq);
  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10: no read can start in the cycle after a walk ends
  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !memReq);
endmodule

// File: rtl/walk_datapath.sv
module walk_datapath
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [LIN_W-1:0]  reqLinAddr,
  input  logic [LIN_W-1:0]  tableBase,
  input  logic [MODE_W-1:0] modeCtl,
  input  logic [ENT_W-1:0]  memData,
  output logic [PHYS_W-1:0] memAddr,
  output logic              entryPresent,
  output logic              entryLarge,
  output logic [PHYS_W-1:0] physAddr,
  output logic [1:0]        pageSize,
  output logic              fault
);
  localparam int HALF_W = ENT_W / 2;
  localparam int UPPER_W = PHYS_W - LIN_W;

  logic [LIN_W-1:0]           linQ, rootQ;
  logic                       extQ, lgpgQ;
  logic [PHYS_W-1:FRAME_LO]   nextBaseQ;
  logic [PHYS_W-1:0]          physQ;
  pageSize_t                  sizeQ;
  logic                       faultQ;
  logic [ENT_W-1:0]           entry;

  always_comb begin
    unique case (strobe.level)
      LV_PTR: memAddr = {{UPPER_W{1'b0}}, rootQ[31:5], linQ[31:30], 3'b000};
      LV_TBL: memAddr = extQ ? {nextBaseQ, linQ[20:12], 3'b000}
                             : {nextBaseQ, linQ[21:12], 2'b00};
      default: memAddr = extQ ? {nextBaseQ, linQ[29:21], 3'b000}
                              : {{UPPER_W{1'b0}}, rootQ[31:12], linQ[31:22], 2'b00};
    endcase
  end

  always_comb begin
    if (extQ) entry = memData;
    else      entry = {{HALF_W{1'b0}}, (memAddr[2] ? memData[ENT_W-1:HALF_W] : memData[HALF_W-1:0])};
  end

  assign entryPresent = entry[0];
  assign entryLarge   = entry[7] && (extQ || lgpgQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      linQ <= '0; rootQ <= '0; extQ <= 1'b0; lgpgQ <= 1'b0;
      nextBaseQ <= '0; physQ <= '0; sizeQ <= PG_4K; faultQ <= 1'b0;
    end else if (strobe.latchReq) begin
      linQ   <= reqLinAddr;
      rootQ  <= tableBase;
      extQ   <= modeCtl[EXT_BIT];
      lgpgQ  <= modeCtl[LGPG_BIT];
      physQ  <= '0;
      sizeQ  <= PG_4K;
      faultQ <= 1'b0;
    end else if (strobe.capture) begin
      if (!entryPresent) begin
        faultQ <= 1'b1;
        physQ  <= '0;
      end else begin
        unique case (strobe.level)
          LV_PTR: nextBaseQ <= entry[PHYS_W-1:FRAME_LO];
          LV_DIR: begin
            if (entryLarge && extQ) begin
              physQ <= {entry[35:21], linQ[20:0]};
              sizeQ <= PG_2M;
            end else if (entryLarge) begin
              physQ <= {{UPPER_W{1'b0}}, entry[31:22], linQ[21:0]};
              sizeQ <= PG_4M;
            end else begin
              nextBaseQ <= extQ ? entry[PHYS_W-1:FRAME_LO]
                                : {{UPPER_W{1'b0}}, entry[31:FRAME_LO]};
            end
          end
          default: begin
            physQ <= extQ ? {entry[35:12], linQ[11:0]}
                          : {{UPPER_W{1'b0}}, entry[31:12], linQ[11:0]};
            sizeQ <= PG_4K;
          end
        endcase
      end
    end
  end

  assign physAddr = physQ;
  assign pageSize = sizeQ;
  assign fault    = faultQ;

  // R2: legacy results never reach above 4 GB
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !extQ |-> (physQ[PHYS_W-1:LIN_W] == '0));
  // R8: a faulted walk carries no address
  p_fault_no_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultQ |-> (physQ == '0));
  // R3: extended entry reads are doubleword aligned
  p_ext_align_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && extQ) |-> (memAddr[2:0] == 3'b000));
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqLinAddr,
  input  logic [31:0] tableBase,
  input  logic [7:0]  modeCtl,
  output logic        memReq,
  output logic [35:0] memAddr,
  input  logic        memAck,
  input  logic [63:0] memData,
  output logic        done,
  output logic [35:0] physAddr,
  output logic [1:0]  pageSize,
  output logic        fault
);
  walkStrobe_t strobe;
  logic entryPresent, entryLarge;

  walk_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .extMode(modeCtl[EXT_BIT]),
    .memAck(memAck), .entryPresent(entryPresent), .entryLarge(entryLarge),
    .strobe(strobe), .memReq(memReq), .done(done)
  );

  walk_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqLinAddr(reqLinAddr),
    .tableBase(tableBase), .modeCtl(modeCtl), .memData(memData),
    .memAddr(memAddr), .entryPresent(entryPresent), .entryLarge(entryLarge),
    .physAddr(physAddr), .pageSize(pageSize), .fault(fault)
  );
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqLinAddr = '0;
  logic [31:0] tableBase = '0;
  logic [7:0]  modeCtl = '0;
  logic        memReq;
  logic [35:0] memAddr;
  logic        memAck = 1'b0;
  logic [63:0] memData = '0;
  logic        done;
  logic [35:0] physAddr;
  logic [1:0]  pageSize;
  logic        fault;

  int checks = 0, fails = 0;
  int readCnt = 0, reqCycles = 0, ackDelay = 0, waitCnt = 0;
  bit finished = 0;

  localparam logic [31:0] EXT_ROOT = 32'h0001_001F;
  localparam logic [31:0] LEG_ROOT = 32'h0002_0FFF;

  logic [63:0] memory [logic [32:0]];

  page_walker i_page_walker (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0]  mode;
    logic [31:0] lin;
    logic [35:0] phys;
    logic [1:0]  size;
    logic        flt;
    logic [2:0]  reads;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h20, 32'h4060_3ABC, 36'hA_BCDE_FABC, 2'd0, 1'b0, 3'd3},  // R5 R4 R3
    '{8'h20, 32'h4080_1234, 36'hF_FE00_1234, 2'd1, 1'b0, 3'd2},  // R6
    '{8'h30, 32'h4060_3ABC, 36'hA_BCDE_FABC, 2'd0, 1'b0, 3'd3},  // R7 precedence
    '{8'h20, 32'hC000_0000, 36'h0,           2'd0, 1'b1, 3'd1},  // R8 pointer
    '{8'h20, 32'h4060_4000, 36'h0,           2'd0, 1'b1, 3'd3},  // R8 table
    '{8'h00, 32'h0040_5678, 36'h0_7654_3678, 2'd0, 1'b0, 3'd2},  // R2
    '{8'h10, 32'h0081_2345, 36'h0_FFC1_2345, 2'd2, 1'b0, 3'd1},  // R7 4 MB
    '{8'h00, 32'h0081_2345, 36'h0,           2'd0, 1'b1, 3'd2}   // R7 bit ignored
  };

  function automatic logic [63:0] rd(logic [35:0] a);
    if (memory.exists(a[35:3])) return memory[a[35:3]];
    return 64'h0;
  endfunction

  task automatic put64(logic [35:0] a, logic [63:0] d);
    memory[a[35:3]] = d;
  endtask

  task automatic put32(logic [35:0] a, logic [31:0] d);
    logic [63:0] w;
    w = rd(a);
    if (a[2]) w[63:32] = d; else w[31:0] = d;
    memory[a[35:3]] = w;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0; waitCnt <= 0;
    end else if (memReq && !memAck) begin
      if (waitCnt >= ackDelay) begin
        memAck <= 1'b1; memData <= rd(memAddr); waitCnt <= 0; readCnt <= readCnt + 1;
      end else waitCnt <= waitCnt + 1;
    end else memAck <= 1'b0;
  end

  always @(negedge clk) if (memReq) reqCycles <= reqCycles + 1;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic runWalk(logic [7:0] mode, logic [31:0] lin, bit busy, logic [31:0] busyLin);
    @(negedge clk);
    readCnt = 0; reqCycles = 0;
    modeCtl = mode; reqLinAddr = lin;
    tableBase = mode[5] ? EXT_ROOT : LEG_ROOT;
    reqValid = 1'b1;
    @(negedge clk);
    if (busy) reqLinAddr = busyLin; else reqValid = 1'b0;
    while (!done) @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    // extended tables
    put64({4'h0, EXT_ROOT[31:5], 2'd1, 3'b0}, 64'hFFF0_0008_0000_0001);
    put64(36'h8_0000_0018, 64'h0000_0009_1234_5001);
    put64(36'h9_1234_5018, 64'h0000_000A_BCDE_F001);
    put64(36'h8_0000_0020, 64'h0000_000F_FE00_0081);
    // legacy tables
    put32(36'h0_0002_0004, 32'h0003_0001);
    put32(36'h0_0002_0008, 32'hFFC0_0081);
    put32(36'h0_0003_0010, 32'h1111_1001);
    put32(36'h0_0003_0014, 32'h7654_3001);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 done", done, 0);
    check("R1 memReq", memReq, 0);
    check("R1 fault", fault, 0);
    check("R1 physAddr", physAddr, 0);

    for (int i = 0; i < NV; i++) begin
      runWalk(VECS[i].mode, VECS[i].lin, 0, 0);
      $display("vector %0d", i);
      check("R2-R8 physAddr", physAddr, VECS[i].phys);
      check("R5 R6 R7 pageSize", pageSize, VECS[i].size);
      check("R8 fault", fault, VECS[i].flt);
      check("R8 read count", readCnt, VECS[i].reads);
    end

    // R9: single-cycle done, results held
    runWalk(8'h20, 32'h4060_3ABC, 0, 0);
    @(negedge clk);
    check("R9 done low next cycle", done, 0);
    repeat (5) @(negedge clk);
    check("R9 physAddr held", physAddr, 36'hA_BCDE_FABC);
    check("R9 pageSize held", pageSize, 0);

    // R10: request during a busy walk is ignored
    runWalk(8'h20, 32'h4060_3ABC, 1, 32'h4080_1234);
    check("R10 busy request ignored", physAddr, 36'hA_BCDE_FABC);
    check("R10 busy reads", readCnt, 3);

    // R10: request held through slow acknowledge
    ackDelay = 3;
    runWalk(8'h20, 32'h4080_1234, 0, 0);
    check("R10 slow-ack result", physAddr, 36'hF_FE00_1234);
    check("R10 request cycles", reqCycles, 10);
    check("R10 slow-ack reads", readCnt, 2);
    ackDelay = 0;

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule